// File: doc/BRIEF.md
# Serial-to-Parallel Symbol Sampler

This block turns a slow serial bit stream into parallel symbol words for a modulator further down the chain. A single free-running counter on the 50 MHz master clock produces two rate strobes. The data strobe fires once every 512 cycles. The symbol strobe fires once every 2048 cycles, so it runs at one quarter of the data rate. The sample clock is the master clock itself, and no generated clocks exist: both rates are one-cycle enables in the master clock domain.

On each data strobe the block takes one serial bit into the low end of a left-shifting register. On each symbol strobe it copies that register into the parallel output word. Between symbol strobes the word stays constant, so the consumer sees one word per symbol period. The stream is paced entirely by the internal counter. There is no valid/ready handshake and no back-pressure: the symbol strobe is the only qualifier for the word. The serial source must present its bit in the cycle in which the data strobe is high.

Top module: `ser_par_sampler`

## Requirements
- R1: While `rst` is high, and in the cycle right after it is released, `word_out`, `data_stb` and `sym_stb` are all zero. Reset also clears the internal counter and the shift register.
- R2: `data_stb` is high for exactly one cycle after rising clock edge number 256 following reset release (edge 1 being the first edge with `rst` low). It then repeats every 512 cycles.
- R3: `sym_stb` is high for exactly one cycle after rising edge number 1024 following reset release. It then repeats every 2048 cycles.
- R4: `data_stb` and `sym_stb` are never high in the same cycle. Exactly four data strobes occur between two consecutive symbol strobes.
- R5: At a rising edge where `data_stb` is high, `ser_in` enters bit 0 of the shift register and the older bits each move up by one position. At every other edge the shift register holds its value.
- R6: `word_out` takes the shift register value only at a rising edge where `sym_stb` is high. At every other edge it holds its value.
- R7: Of the four bits shifted in between two symbol strobes, the first appears in `word_out` bit 3 and the last in bit 0.
- R8: The counter wraps after 2048 cycles with no gap, so the strobe pattern repeats unchanged for as long as reset stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz master clock, also used as the sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data bit, taken when data_stb is high |
| word_out | output | 4 | Parallel word captured at the last symbol strobe |
| data_stb | output | 1 | One-cycle data-rate strobe |
| sym_stb | output | 1 | One-cycle symbol-rate strobe |

## Verification
The bench measures the exact phase of the first strobes after reset. A design that is off by one cycle, or that fires on the falling half of a counter bit, moves every later strobe and fails on the first comparison. It checks across several counter wraps that the output word changes only at symbol strobes. A design that copies on each shift would show partial words. A directed pattern with a single one bit shows whether the bit order is reversed, and a reset applied mid-run shows whether the counter phase or the stale word survives reset.

// File: rtl/ser_par_pkg.sv
package ser_par_pkg;

  typedef struct packed {
    logic data;
    logic sym;
  } rate_stb_t;

  function automatic int ratio_of(input int data_tap, input int sym_tap);
    return 1 << (sym_tap - data_tap);
  endfunction

endpackage

// File: rtl/sps_rate_gen.sv
module sps_rate_gen
  import ser_par_pkg::*;
#(
  parameter int DATA_TAP = 8,
  parameter int SYM_TAP  = 10
) (
  input  logic      clk,
  input  logic      rst,
  output rate_stb_t stb
);
  localparam int CNT_W    = SYM_TAP + 1;
  localparam int D_PERIOD = 1 << (DATA_TAP + 1);
  localparam int RATIO    = ratio_of(DATA_TAP, SYM_TAP);
  localparam logic [DATA_TAP:0] D_PRE = {1'b0, {DATA_TAP{1'b1}}};
  localparam logic [SYM_TAP:0]  S_PRE = {1'b0, {SYM_TAP{1'b1}}};

  logic [CNT_W-1:0] cnt;

  // strobe is registered so it is high in the first cycle the tap bit reads 1
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      stb.data <= 1'b0;
      stb.sym  <= 1'b0;
    end else begin
      cnt      <= cnt + 1'b1;
      stb.data <= (cnt[DATA_TAP:0] == D_PRE);
      stb.sym  <= (cnt[SYM_TAP:0] == S_PRE);
    end
  end

  // checker state: spacing of data strobes and count per symbol
  logic [DATA_TAP+1:0]         d_gap;
  logic                        d_seen;
  logic [SYM_TAP-DATA_TAP+1:0] d_per_sym;
  logic                        s_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_gap     <= '0;
      d_seen    <= 1'b0;
      d_per_sym <= '0;
      s_seen    <= 1'b0;
    end else begin
      if (stb.data) begin
        d_gap  <= 1;
        d_seen <= 1'b1;
      end else if (d_gap <= (DATA_TAP+2)'(D_PERIOD)) begin
        d_gap <= d_gap + 1'b1;
      end
      if (stb.sym) begin
        d_per_sym <= '0;
        s_seen    <= 1'b1;
      end else if (stb.data) begin
        d_per_sym <= d_per_sym + 1'b1;
      end
    end
  end

  p_data_onecycle_r2: assert property (@(posedge clk) disable iff (rst)
    stb.data |=> !stb.data);
  p_sym_onecycle_r3: assert property (@(posedge clk) disable iff (rst)
    stb.sym |=> !stb.sym);
  p_data_period_r2: assert property (@(posedge clk) disable iff (rst)
    (stb.data && d_seen) |-> (d_gap == (DATA_TAP+2)'(D_PERIOD)));
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    !(stb.data && stb.sym));
  p_four_per_sym_r4: assert property (@(posedge clk) disable iff (rst)
    (stb.sym && s_seen) |-> (d_per_sym == (SYM_TAP-DATA_TAP+2)'(RATIO)));
endmodule

// File: rtl/sps_shift.sv
module sps_shift #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= {q[W-2:0], din};
  end

  p_shift_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(q));
  p_shift_clear_r1: assert property (@(posedge clk)
    rst |=> (q == '0));
endmodule

// File: rtl/sps_latch.sv
module sps_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  p_word_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
  p_word_clear_r1: assert property (@(posedge clk)
    rst |=> (q == '0));
endmodule

// File: rtl/ser_par_sampler.sv
module ser_par_sampler
  import ser_par_pkg::*;
#(
  parameter int DATA_TAP = 8,
  parameter int SYM_TAP  = 10,
  parameter int WORD_W   = 1 << (SYM_TAP - DATA_TAP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  output logic [WORD_W-1:0] word_out,
  output logic              data_stb,
  output logic              sym_stb
);
  rate_stb_t         stb;
  logic [WORD_W-1:0] sr;

  sps_rate_gen #(.DATA_TAP(DATA_TAP), .SYM_TAP(SYM_TAP)) u_rate (
    .clk (clk),
    .rst (rst),
    .stb (stb)
  );

  sps_shift #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (stb.data),
    .din      (ser_in),
    .q        (sr)
  );

  sps_latch #(.W(WORD_W)) u_latch (
    .clk  (clk),
    .rst  (rst),
    .load (stb.sym),
    .d    (sr),
    .q    (word_out)
  );

  assign data_stb = stb.data;
  assign sym_stb  = stb.sym;

  p_idle_after_reset_r1: assert property (@(posedge clk)
    rst |=> (!data_stb && !sym_stb && word_out == '0));
endmodule

// File: tb/ser_par_sampler_tb.sv
module ser_par_sampler_tb;
  localparam int CLK_PERIOD = 20;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_in = 1'b0;
  logic [3:0] word_out;
  logic       data_stb, sym_stb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_par_sampler u_dut (
    .clk(clk), .rst(rst), .ser_in(ser_in),
    .word_out(word_out), .data_stb(data_stb), .sym_stb(sym_stb)
  );

  // model of the requirements: edges counted since reset release
  logic [10:0] m_cnt;
  logic        m_dstb, m_sstb;
  logic [3:0]  m_sr, m_word;

  function automatic logic next_dstb(input logic [10:0] c);
    return c[8:0] == 9'd255;   // R2: high after edge 256 mod 512
  endfunction
  function automatic logic next_sstb(input logic [10:0] c);
    return c == 11'd1023;      // R3: high after edge 1024 mod 2048
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_cnt <= '0; m_dstb <= 0; m_sstb <= 0; m_sr <= '0; m_word <= '0;
    end else begin
      m_cnt  <= m_cnt + 1'b1;  // R8: wraps freely
      m_dstb <= next_dstb(m_cnt);
      m_sstb <= next_sstb(m_cnt);
      if (m_dstb) m_sr <= {m_sr[2:0], ser_in};   // R5
      if (m_sstb) m_word <= m_sr;                // R6
    end
  end

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    check("R2", {3'b0, data_stb}, {3'b0, m_dstb});
    check("R3", {3'b0, sym_stb},  {3'b0, m_sstb});
    check("R6", word_out, m_word);
    checks++;
    if (data_stb && sym_stb) begin
      errors++;
      $display("FAIL R4 actual=both strobes expected=not both at cycle %0d", cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    int dcount;
    int first_d;
    int first_s;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", word_out, 4'b0);
    check("R1", {2'b0, data_stb, sym_stb}, 4'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {data_stb, sym_stb, word_out[1:0]}, 4'b0);

    // R2/R3: phase of first strobes, counted in edges since release
    first_d = 0; first_s = 0;
    for (int e = 1; e <= 1100; e++) begin
      if (e > 1) @(negedge clk);
      if (data_stb && first_d == 0) first_d = e;
      if (sym_stb && first_s == 0) first_s = e;
      compare_all();
    end
    check("R2 first", first_d[3:0], 4'(256 % 16));
    checks++; if (first_d != 256) begin errors++; $display("FAIL R2 actual=%0d expected=256", first_d); end
    checks++; if (first_s != 1024) begin errors++; $display("FAIL R3 actual=%0d expected=1024", first_s); end

    // R7 directed: shift 1,0,0,0 then 0,1,1,0 into two symbol periods
    for (int p = 0; p < 2; p++) begin
      logic [3:0] pat;
      pat = (p == 0) ? 4'b1000 : 4'b0110;
      while (!sym_stb) begin @(negedge clk); compare_all(); end
      dcount = 0;
      @(negedge clk); compare_all();
      while (!sym_stb) begin
        if (data_stb) begin
          ser_in = (dcount < 4) ? pat[3-dcount] : 1'b0;
          dcount++;
        end
        @(negedge clk); compare_all();
      end
      checks++; if (dcount != 4) begin errors++; $display("FAIL R4 actual=%0d expected=4", dcount); end
      @(negedge clk); compare_all();
      check("R7", word_out, pat);
    end

    // random stimulus across several counter wraps (R5, R6, R8)
    for (int i = 0; i < 20000; i++) begin
      ser_in = 1'($urandom);
      @(negedge clk); compare_all();
    end

    // mid-run reset (R1) and restart phase
    rst = 1'b1;
    repeat (3) begin @(negedge clk); compare_all(); end
    check("R1 mid", word_out, 4'b0);
    rst = 1'b0;
    for (int i = 0; i < 12000; i++) begin
      ser_in = 1'($urandom);
      @(negedge clk); compare_all();
    end
    finish_run();
  end
endmodule